// File: doc/BRIEF.md
# Buffered Compare/Capture Timer Channel

This block is one channel of a 16-bit timer. A free-running up-counter is paired with a single compare/capture register. In the two compare modes the register holds a value that the counter is matched against. A match raises an interrupt and can also send the counter back to zero, which sets the period of the channel. In the buffered compare mode, software writes go to a hidden shadow register first. They move into the live compare register only at safe points: when the timer is initialized, or on counter wrap or on a match, as a select bit chooses. Each such move also clears the counter.

In the two capture modes the same register instead records the counter value when an edge arrives on an external event pin. One mode reacts to the edge of a chosen polarity and the other reacts to both edges. The pin is synchronized before any edge is looked for. The channel is controlled through a plain synchronous write/read port for the register value and a small set of static mode inputs.

Top module: `tcc_channel`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count`, `rd_data` and `irq` are all zero.
- R2: When `cnt_en` is 1, `count` increases by one on each clock and wraps from 0xFFFF to 0x0000. When `cnt_en` is 0, it holds its value, unless it is being cleared.
- R3: In mode 2'b00 (plain compare) or 2'b01 (buffered compare), a cycle with `cnt_en`=1 and `count` equal to `rd_data` is a match. The match drives `irq` high for exactly the following cycle.
- R4: With `clr_on_match`=1, a match sets `count` to 0 on the next clock. The interval between matches is therefore `rd_data`+1 clocks.
- R5: In mode 2'b00 and in both capture modes (2'b10, 2'b11), a write (`wr_en`=1) updates `rd_data` to `wr_data` on the next clock.
- R6: In mode 2'b01, a write changes only the shadow register. `rd_data` keeps its previous value until a transfer happens.
- R7: A one-cycle `init` sets `count` to 0. In mode 2'b01 it also copies the shadow register into `rd_data`.
- R8: In mode 2'b01 with `xfer_on_match`=0, the wrap of `count` from 0xFFFF copies the shadow register into `rd_data` and leaves `count` at 0.
- R9: In mode 2'b01 with `xfer_on_match`=1, a match copies the shadow register into `rd_data` and sets `count` to 0.
- R10: In mode 2'b10, an edge of `evt_pin` latches the counter into `rd_data` and pulses `irq`, but only for a rising edge when `edge_rise`=1 or a falling edge when `edge_rise`=0. The other edge leaves `rd_data` and `irq` unchanged.
- R11: In mode 2'b11, both rising and falling edges of `evt_pin` capture the counter and pulse `irq`.
- R12: A pin change sampled at clock edge k is detected in the cycle after edge k+1. `rd_data` then takes the `count` value shown in that cycle, at edge k+2, and `irq` is high for the cycle after edge k+2. A capture takes precedence over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter advance enable |
| init | input | 1 | Timer initialize pulse |
| clr_on_match | input | 1 | Clear counter after a compare match |
| mode | input | 2 | 00 compare, 01 buffered compare, 10 single-edge capture, 11 dual-edge capture |
| edge_rise | input | 1 | Single-edge capture polarity: 1 rising, 0 falling |
| xfer_on_match | input | 1 | Buffered transfer point: 0 wrap, 1 match |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Live compare/capture value |
| count | output | 16 | Current counter value |
| evt_pin | input | 1 | Asynchronous capture event pin |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Counter updates, writes, transfers and the match interrupt all appear one clock edge after the cycle that causes them. A capture appears three edges after the pin changes: two for synchronizing and one to latch. The bench runs a behavioural model that advances at the same rising edge as the design and keeps the pin history in a queue. It compares `count`, `rd_data` and `irq` on every falling edge, so each result is checked in exactly the cycle it is due. A full wrap of the counter is run once, so that the wrap-triggered transfer is checked too.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        MODE_CMP  = 2'b00,
        MODE_DBUF = 2'b01,
        MODE_CAP1 = 2'b10,
        MODE_CAP2 = 2'b11
    } tcc_mode_e;

    typedef struct packed {
        logic match;
        logic xfer;
        logic cap;
    } tcc_evt_t;

    function automatic logic is_compare(tcc_mode_e m);
        return (m == MODE_CMP) || (m == MODE_DBUF);
    endfunction

    function automatic logic capture_hit(tcc_mode_e m, logic pol_rise,
                                         logic rise, logic fall);
        logic hit;
        case (m)
            MODE_CAP1: hit = pol_rise ? rise : fall;
            MODE_CAP2: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[LAST];
    end

    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;

    // R11
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rise && fall));
    // R12
    rise_once_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         clear,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (en)    cnt_q <= cnt_q + ONE;
    end

    assign cnt  = cnt_q;
    assign wrap = en && (cnt_q == TOP);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !clear) |=> cnt_q == $past(cnt_q) + ONE);
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !clear) |=> $stable(cnt_q));
    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt_q == '0);

endmodule

// File: rtl/tcc_cc_reg.sv
module tcc_cc_reg
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  tcc_mode_e    mode,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         xfer,
    input  logic         cap,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] active
);
    logic [W-1:0] act_q;
    logic [W-1:0] shadow_q;
    logic         to_shadow;

    assign to_shadow = wr && (mode == MODE_DBUF);

    always_ff @(posedge clk) begin
        if (rst)            shadow_q <= '0;
        else if (to_shadow) shadow_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)          act_q <= '0;
        else if (cap)     act_q <= cnt;
        else if (xfer)    act_q <= shadow_q;
        else if (wr && !to_shadow) act_q <= wdata;
    end

    assign active = act_q;

    // R12
    cap_latch_chk: assert property (@(posedge clk) disable iff (rst)
        cap |=> act_q == $past(cnt));
    // R6
    dbuf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (to_shadow && !xfer && !cap) |=> $stable(act_q));
    // R8
    xfer_load_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && !cap) |=> act_q == $past(shadow_q));

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int W    = 16,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         init,
    input  logic         clr_on_match,
    input  logic [1:0]   mode,
    input  logic         edge_rise,
    input  logic         xfer_on_match,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] count,
    input  logic         evt_pin,
    output logic         irq
);
    tcc_mode_e    md;
    tcc_evt_t     ev;
    logic [W-1:0] cnt_w;
    logic [W-1:0] act_w;
    logic         wrap_w;
    logic         rise_w;
    logic         fall_w;
    logic         cnt_clear;
    logic         irq_q;

    assign md = tcc_mode_e'(mode);

    tcc_edge_sync #(.STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (evt_pin),
        .rise (rise_w),
        .fall (fall_w)
    );

    tcc_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (cnt_en),
        .clear (cnt_clear),
        .cnt   (cnt_w),
        .wrap  (wrap_w)
    );

    always_comb begin
        ev.match = is_compare(md) && cnt_en && (cnt_w == act_w);
        ev.xfer  = (md == MODE_DBUF) &&
                   (init || (xfer_on_match ? ev.match : wrap_w));
        ev.cap   = capture_hit(md, edge_rise, rise_w, fall_w);
        cnt_clear = init || ev.xfer || (clr_on_match && ev.match);
    end

    tcc_cc_reg #(.W(W)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .mode   (md),
        .wr     (wr_en),
        .wdata  (wr_data),
        .xfer   (ev.xfer),
        .cap    (ev.cap),
        .cnt    (cnt_w),
        .active (act_w)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= ev.match | ev.cap;
    end

    assign irq     = irq_q;
    assign rd_data = act_w;
    assign count   = cnt_w;

    // R3
    match_irq_chk: assert property (@(posedge clk) disable iff (rst)
        ev.match |=> irq);
    // R9
    xfer_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ev.xfer |=> count == '0);
    // R4
    clr_match_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.match && clr_on_match) |=> count == '0);
    // R10
    quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!ev.match && !ev.cap) |=> !irq);

endmodule

// File: tb/sim_tcc_channel.sv
module sim_tcc_channel;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0, init = 1'b0, clr_on_match = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        edge_rise = 1'b1, xfer_on_match = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        evt_pin = 1'b0;
    logic [15:0] rd_data, count;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    tcc_channel u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .init(init),
        .clr_on_match(clr_on_match), .mode(mode), .edge_rise(edge_rise),
        .xfer_on_match(xfer_on_match), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .count(count), .evt_pin(evt_pin), .irq(irq)
    );

    // behavioural reference
    logic [15:0] m_cnt = '0, m_val = '0, m_shadow = '0;
    logic        m_irq = 1'b0;
    logic        pin_hist[$] = '{1'b0, 1'b0, 1'b0};

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_val = '0; m_shadow = '0; m_irq = 1'b0;
            pin_hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit cmp_on, hit, wrapped, moved, up, down, grab;
            logic [15:0] n_cnt, n_val, n_shadow;
            cmp_on  = (mode == 2'b00) || (mode == 2'b01);
            hit     = cmp_on && cnt_en && (m_cnt == m_val);
            wrapped = cnt_en && (m_cnt == 16'hFFFF);
            moved   = (mode == 2'b01) && (init || (xfer_on_match ? hit : wrapped));
            up      = pin_hist[1] && !pin_hist[2];
            down    = !pin_hist[1] && pin_hist[2];
            grab    = (mode == 2'b10) ? (edge_rise ? up : down)
                    : (mode == 2'b11) ? (up || down) : 1'b0;
            if (init || moved || (clr_on_match && hit)) n_cnt = '0;
            else if (cnt_en) n_cnt = m_cnt + 16'd1;
            else n_cnt = m_cnt;
            n_shadow = (wr_en && mode == 2'b01) ? wr_data : m_shadow;
            if (grab) n_val = m_cnt;
            else if (moved) n_val = m_shadow;
            else if (wr_en && mode != 2'b01) n_val = wr_data;
            else n_val = m_val;
            m_irq = hit || grab;
            m_cnt = n_cnt; m_val = n_val; m_shadow = n_shadow;
            pin_hist.push_front(evt_pin);
            void'(pin_hist.pop_back());
        end
    end

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tests++;
            if (count !== m_cnt || rd_data !== m_val || irq !== m_irq) begin
                fails++;
                $display("FAIL %s: count=%h rd=%h irq=%b expected count=%h rd=%h irq=%b",
                         req, count, rd_data, irq, m_cnt, m_val, m_irq);
            end
        end
    endtask

    task automatic write(input logic [15:0] v, input string req);
        wr_en = 1'b1; wr_data = v;
        run(1, req);
        wr_en = 1'b0;
    endtask

    task automatic pulse_init(input string req);
        init = 1'b1;
        run(1, req);
        init = 1'b0;
    endtask

    initial begin
        run(3, "R1");
        rst = 1'b0;
        run(1, "R1");
        // R2 count, hold
        cnt_en = 1'b1; run(20, "R2");
        cnt_en = 1'b0; run(5, "R2");
        // R5 then R3 match pulse
        write(16'd30, "R5");
        cnt_en = 1'b1; run(40, "R3");
        // R4 period value+1
        write(16'd9, "R5");
        clr_on_match = 1'b1;
        pulse_init("R7");
        run(35, "R4");
        // R6 buffered write, R9 transfer on match
        mode = 2'b01; xfer_on_match = 1'b1;
        write(16'd5, "R6");
        run(30, "R9");
        // R7 init transfer
        write(16'd12, "R6");
        run(3, "R6");
        pulse_init("R7");
        run(5, "R7");
        // R8 transfer on wrap, R2 wrap
        clr_on_match = 1'b0; xfer_on_match = 1'b0;
        write(16'd100, "R6");
        run(65600, "R8");
        // R10 single edge, both polarities
        mode = 2'b10; edge_rise = 1'b1;
        evt_pin = 1'b1; run(8, "R10");
        evt_pin = 1'b0; run(8, "R10");
        edge_rise = 1'b0;
        evt_pin = 1'b1; run(8, "R10");
        evt_pin = 1'b0; run(8, "R10");
        // R11 dual edge, R12 capture beats write
        mode = 2'b11;
        evt_pin = 1'b1; run(8, "R11");
        evt_pin = 1'b0; run(8, "R11");
        evt_pin = 1'b1; run(1, "R12");
        run(1, "R12");
        write(16'hBEEF, "R12");
        run(6, "R12");
        cnt_en = 1'b0;
        evt_pin = 1'b0; run(8, "R12");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule